// File: doc/BRIEF.md
# Seven-Segment Space-Vector Switching Sequencer

This block turns one modulation period's worth of space-vector data into the three upper-switch states of a two-level three-phase bridge. It receives a sector number (1 to 6), two active-vector dwell counts, the carrier half-period length and a running triangular carrier count. For each modulation period it plays the symmetric seven-segment pattern against that carrier: an outer zero state, the first active vector, the second active vector, a middle zero state, the second active vector again, the first active vector again, and a closing outer zero state.

Segment edges are found by comparing the carrier count with three thresholds. The thresholds are computed from the dwell counts and the leftover zero time. The same count value on the rising and the falling slope of the carrier gives the same switch state, so the pattern is mirror-symmetric about the carrier peak. Sector, dwell and half-period inputs take effect only when the carrier count is zero, so one period never mixes two sets of inputs. Dwell requests that do not fit in the half-period are clamped. A sector code outside 1..6 keeps the previous active pair. The angle calculation, the dwell calculation and dead-time insertion belong to neighbouring blocks.

Top module: `svm7_sequencer`

## Requirements
- R1: Synchronous active-high reset drives leg_a, leg_b and leg_c to 0 and seg_idx to 0 at the next clock edge. It also clears the latched thresholds and the direction flag (direction becomes "up") and loads the sector-1 active pair.
- R2: Outputs are registered. The outputs after clock edge k+1 reflect the carrier sampled at edge k. With thresholds A <= B <= C, seg_idx is defined as follows. On the rising slope it is 0 for count < A, 1 for count < B, 2 for count < C, and 3 otherwise. On the falling slope it is 6 for count < A, 5 for count < B, 4 for count < C, and 3 otherwise.
- R3: A switch vector is written as three bits {a,b,c}: bit 2 drives leg_a, bit 1 drives leg_b and bit 0 drives leg_c, and a 1 means the upper switch is on. Segments 0 and 6 output 000, and segment 3 outputs 111.
- R4: The active pair (first, second) for sectors 1..6 is (100,110), (110,010), (010,011), (011,001), (001,101), (101,100). Segments 1 and 5 output the first vector, and segments 2 and 4 output the second.
- R5: The first active vector covers the dwell1 count values in [A, A+dwell1), and the second covers the dwell2 values in [B, B+dwell2). A dwell of 0 removes that segment.
- R6: With zero time Z = half_len − dwell1 − dwell2, A = floor(Z/2). The middle zero gets the remaining ceil(Z/2) counts, from C up to half_len.
- R7: If dwell1 exceeds half_len it is clamped to half_len. If dwell2 exceeds what is left, it is clamped to half_len − dwell1. No segment ever has negative length.
- R8: A sector code of 0 or 7 in the latch cycle leaves the active pair unchanged, while the thresholds are still updated.
- R9: Sector, dwell and half-period inputs are captured only in a cycle where the carrier count is 0. Changes at any other time have no effect until the next zero.
- R10: The slope is "down" when the carrier count is below the previous sample and "up" when it is above. An equal count keeps the previous slope.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sector_in | input | 3 | Sector number 1..6 |
| dwell1 | input | CW | First active-vector dwell, in carrier counts per half-period |
| dwell2 | input | CW | Second active-vector dwell, in carrier counts per half-period |
| half_len | input | CW | Carrier peak value (half-period length) |
| carrier | input | CW | Triangular carrier count |
| leg_a | output | 1 | Upper-switch state, leg a |
| leg_b | output | 1 | Upper-switch state, leg b |
| leg_c | output | 1 | Upper-switch state, leg c |
| seg_idx | output | 3 | Current segment 0..6 |

## Verification
The hardest situations to reach are thresholds that coincide. These occur with zero-length segments, a clamped dwell that leaves no zero time, and a slope decision made while the carrier is held at one value; a steady free-running carrier never produces any of them. The stimulus drives the carrier directly as a sequence of count values, so it can insert repeated counts on both slopes, and it pairs that with dwell sets whose sum equals or exceeds the half-period. It also changes the inputs partway through a period, and a behavioural model checks that only the values present at the count of zero take effect.

// File: rtl/svm7_pkg.sv
package svm7_pkg;

  typedef logic [2:0] vec_t;

  localparam vec_t VEC_ALL_LOW  = 3'b000;
  localparam vec_t VEC_ALL_HIGH = 3'b111;

  typedef enum logic [2:0] {
    SEG_ZERO_OPEN  = 3'd0,
    SEG_ACT1_RISE  = 3'd1,
    SEG_ACT2_RISE  = 3'd2,
    SEG_ZERO_MID   = 3'd3,
    SEG_ACT2_FALL  = 3'd4,
    SEG_ACT1_FALL  = 3'd5,
    SEG_ZERO_CLOSE = 3'd6
  } seg_t;

  // Active vectors around the hexagon, in order of increasing angle.
  function automatic vec_t ring_vec(input logic [2:0] idx);
    case (idx)
      3'd0:    ring_vec = 3'b100;
      3'd1:    ring_vec = 3'b110;
      3'd2:    ring_vec = 3'b010;
      3'd3:    ring_vec = 3'b011;
      3'd4:    ring_vec = 3'b001;
      3'd5:    ring_vec = 3'b101;
      default: ring_vec = 3'b000;
    endcase
  endfunction

endpackage

// File: rtl/svm7_sector_map.sv
module svm7_sector_map
  import svm7_pkg::*;
(
  input  logic [2:0] sector,
  output logic       valid,
  output vec_t       act_first,
  output vec_t       act_second
);

  logic [2:0] idx_lo;
  logic [2:0] idx_hi;

  always_comb begin
    valid      = (sector != 3'd0) && (sector != 3'd7);
    idx_lo     = sector - 3'd1;
    idx_hi     = (sector == 3'd6) ? 3'd0 : sector;
    act_first  = ring_vec(idx_lo);
    act_second = ring_vec(idx_hi);
  end

endmodule

// File: rtl/svm7_dwell_plan.sv
module svm7_dwell_plan #(
  parameter int CW = 12
) (
  input  logic [CW-1:0] dwell1,
  input  logic [CW-1:0] dwell2,
  input  logic [CW-1:0] half_len,
  output logic [CW-1:0] th_a,
  output logic [CW-1:0] th_b,
  output logic [CW-1:0] th_c
);

  logic [CW-1:0] d1_fit;
  logic [CW-1:0] room;
  logic [CW-1:0] d2_fit;
  logic [CW-1:0] zero_all;

  always_comb begin
    d1_fit   = (dwell1 > half_len) ? half_len : dwell1;
    room     = half_len - d1_fit;
    d2_fit   = (dwell2 > room) ? room : dwell2;
    zero_all = room - d2_fit;
    th_a     = zero_all >> 1;
    th_b     = th_a + d1_fit;
    th_c     = th_b + d2_fit;
  end

endmodule

// File: rtl/svm7_seg_select.sv
module svm7_seg_select
  import svm7_pkg::*;
#(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] cnt_q,
  input  logic          slope_down,
  input  logic [CW-1:0] th_a,
  input  logic [CW-1:0] th_b,
  input  logic [CW-1:0] th_c,
  input  vec_t          act_first,
  input  vec_t          act_second,
  output logic [2:0]    legs,
  output logic [2:0]    seg
);

  seg_t seg_n;
  vec_t vec_n;

  always_comb begin
    if (cnt_q < th_a)
      seg_n = slope_down ? SEG_ZERO_CLOSE : SEG_ZERO_OPEN;
    else if (cnt_q < th_b)
      seg_n = slope_down ? SEG_ACT1_FALL : SEG_ACT1_RISE;
    else if (cnt_q < th_c)
      seg_n = slope_down ? SEG_ACT2_FALL : SEG_ACT2_RISE;
    else
      seg_n = SEG_ZERO_MID;

    case (seg_n)
      SEG_ACT1_RISE, SEG_ACT1_FALL: vec_n = act_first;
      SEG_ACT2_RISE, SEG_ACT2_FALL: vec_n = act_second;
      SEG_ZERO_MID:                 vec_n = VEC_ALL_HIGH;
      default:                      vec_n = VEC_ALL_LOW;
    endcase
  end

  for (genvar g = 0; g < 3; g++) begin : g_leg
    always_ff @(posedge clk) begin
      if (rst) legs[g] <= 1'b0;
      else     legs[g] <= vec_n[g];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) seg <= 3'd0;
    else     seg <= seg_n;
  end

endmodule

// File: rtl/svm7_sequencer.sv
module svm7_sequencer
  import svm7_pkg::*;
#(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [2:0]    sector_in,
  input  logic [CW-1:0] dwell1,
  input  logic [CW-1:0] dwell2,
  input  logic [CW-1:0] half_len,
  input  logic [CW-1:0] carrier,
  output logic          leg_a,
  output logic          leg_b,
  output logic          leg_c,
  output logic [2:0]    seg_idx
);

  localparam logic [CW-1:0] CNT_ZERO = '0;

  logic [CW-1:0] pa, pb, pc;
  logic          sec_ok;
  vec_t          pv1, pv2;

  logic [CW-1:0] cnt_q;
  logic          down_q;
  logic [CW-1:0] la, lb, lc;
  vec_t          lv1, lv2;
  logic [2:0]    legs;

  svm7_dwell_plan #(.CW(CW)) u_plan (
    .dwell1   (dwell1),
    .dwell2   (dwell2),
    .half_len (half_len),
    .th_a     (pa),
    .th_b     (pb),
    .th_c     (pc)
  );

  svm7_sector_map u_map (
    .sector     (sector_in),
    .valid      (sec_ok),
    .act_first  (pv1),
    .act_second (pv2)
  );

  // Stage 1: carrier sample, slope tracking, period-boundary capture.
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= CNT_ZERO;
      down_q <= 1'b0;
      la     <= CNT_ZERO;
      lb     <= CNT_ZERO;
      lc     <= CNT_ZERO;
      lv1    <= 3'b100;
      lv2    <= 3'b110;
    end else begin
      cnt_q <= carrier;
      if (carrier > cnt_q)      down_q <= 1'b0;
      else if (carrier < cnt_q) down_q <= 1'b1;
      if (carrier == CNT_ZERO) begin
        la <= pa;
        lb <= pb;
        lc <= pc;
        if (sec_ok) begin
          lv1 <= pv1;
          lv2 <= pv2;
        end
      end
    end
  end

  // Stage 2: segment decode and registered switch states.
  svm7_seg_select #(.CW(CW)) u_sel (
    .clk        (clk),
    .rst        (rst),
    .cnt_q      (cnt_q),
    .slope_down (down_q),
    .th_a       (la),
    .th_b       (lb),
    .th_c       (lc),
    .act_first  (lv1),
    .act_second (lv2),
    .legs       (legs),
    .seg        (seg_idx)
  );

  assign leg_a = legs[2];
  assign leg_b = legs[1];
  assign leg_c = legs[0];

endmodule

// File: rtl/svm7_checker.sv
module svm7_checker (
  input logic       clk,
  input logic       rst,
  input logic       leg_a,
  input logic       leg_b,
  input logic       leg_c,
  input logic [2:0] seg_idx
);

  logic       rst_seen = 1'b0;
  logic [2:0] lv;

  assign lv = {leg_a, leg_b, leg_c};

  always_ff @(posedge clk) rst_seen <= rst;

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst_seen |-> (lv == 3'b000 && seg_idx == 3'd0)); // R1

  AST_SEG_RANGE: assert property (@(posedge clk) disable iff (rst)
    seg_idx <= 3'd6); // R2

  AST_OUTER_ZERO: assert property (@(posedge clk) disable iff (rst)
    (seg_idx == 3'd0 || seg_idx == 3'd6) |-> lv == 3'b000); // R3

  AST_MID_ZERO: assert property (@(posedge clk) disable iff (rst)
    seg_idx == 3'd3 |-> lv == 3'b111); // R3

  AST_ACTIVE_VEC: assert property (@(posedge clk) disable iff (rst)
    (seg_idx == 3'd1 || seg_idx == 3'd2 || seg_idx == 3'd4 || seg_idx == 3'd5)
      |-> ($countones(lv) == 1 || $countones(lv) == 2)); // R4

endmodule

bind svm7_sequencer svm7_checker u_chk (
  .clk     (clk),
  .rst     (rst),
  .leg_a   (leg_a),
  .leg_b   (leg_b),
  .leg_c   (leg_c),
  .seg_idx (seg_idx)
);

// File: tb/svm7_sequencer_tb.sv
module svm7_sequencer_tb;

  localparam int CLK_PERIOD = 10;
  localparam int CW = 12;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [2:0]    sector_in = 3'd1;
  logic [CW-1:0] dwell1 = '0;
  logic [CW-1:0] dwell2 = '0;
  logic [CW-1:0] half_len = '0;
  logic [CW-1:0] carrier = '0;
  logic          leg_a, leg_b, leg_c;
  logic [2:0]    seg_idx;

  svm7_sequencer #(.CW(CW)) u_dut (
    .clk(clk), .rst(rst), .sector_in(sector_in), .dwell1(dwell1),
    .dwell2(dwell2), .half_len(half_len), .carrier(carrier),
    .leg_a(leg_a), .leg_b(leg_b), .leg_c(leg_c), .seg_idx(seg_idx)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int    n_vec = 0;
  int    n_bad = 0;
  string tag = "R1";
  bit    done = 0;

  typedef struct { logic [2:0] q; int seg; } exp_t;
  exp_t exp_q[$];

  // Behavioural reference state
  int         m_a = 0, m_b = 0, m_c = 0, m_prev = 0;
  bit         m_down = 0;
  logic [2:0] m_v1 = 3'b100, m_v2 = 3'b110;
  bit         rst_s = 1;

  function automatic logic [2:0] hexvec(int k);
    case (k)
      0: return 3'b100;
      1: return 3'b110;
      2: return 3'b010;
      3: return 3'b011;
      4: return 3'b001;
      default: return 3'b101;
    endcase
  endfunction

  always @(posedge clk) begin : mdl
    int c, h, x1, x2, z, s;
    exp_t e;
    rst_s <= rst;
    if (rst) begin
      m_a = 0; m_b = 0; m_c = 0; m_prev = 0; m_down = 0;
      m_v1 = 3'b100; m_v2 = 3'b110;
      exp_q.delete();
    end else begin
      c = int'(carrier);
      if (c == 0) begin
        h = int'(half_len); x1 = int'(dwell1); x2 = int'(dwell2);
        if (x1 > h) x1 = h;
        if (x2 > h - x1) x2 = h - x1;
        z = h - x1 - x2;
        m_a = z / 2; m_b = m_a + x1; m_c = m_b + x2;
        s = int'(sector_in);
        if (s >= 1 && s <= 6) begin
          m_v1 = hexvec(s - 1);
          m_v2 = hexvec(s % 6);
        end
      end
      if (c > m_prev) m_down = 0;
      else if (c < m_prev) m_down = 1;
      m_prev = c;
      if (c < m_a)      e.seg = m_down ? 6 : 0;
      else if (c < m_b) e.seg = m_down ? 5 : 1;
      else if (c < m_c) e.seg = m_down ? 4 : 2;
      else              e.seg = 3;
      case (e.seg)
        1, 5:    e.q = m_v1;
        2, 4:    e.q = m_v2;
        3:       e.q = 3'b111;
        default: e.q = 3'b000;
      endcase
      exp_q.push_back(e);
    end
  end

  always @(negedge clk) begin : chk
    exp_t e;
    if (!done) begin
      if (rst_s) begin
        n_vec++;
        if ({leg_a, leg_b, leg_c} != 3'b000 || seg_idx != 3'd0) begin
          n_bad++;
          $display("FAIL R1 reset: legs=%b seg=%0d expected legs=000 seg=0",
                   {leg_a, leg_b, leg_c}, seg_idx);
        end
      end else if (exp_q.size() >= 2) begin
        e = exp_q.pop_front();
        n_vec++;
        if ({leg_a, leg_b, leg_c} !== e.q || int'(seg_idx) != e.seg) begin
          n_bad++;
          $display("FAIL %s t=%0t: legs=%b seg=%0d expected legs=%b seg=%0d",
                   tag, $time, {leg_a, leg_b, leg_c}, seg_idx, e.q, e.seg);
        end
      end
    end
  end

  task automatic step(int v);
    @(negedge clk);
    carrier = CW'(v);
  endtask

  task automatic set_in(int sec, int x1, int x2, int h);
    sector_in = 3'(sec);
    dwell1 = CW'(x1);
    dwell2 = CW'(x2);
    half_len = CW'(h);
  endtask

  // One full carrier period starting at count 0.
  task automatic period(int sec, int x1, int x2, int h);
    @(negedge clk);
    set_in(sec, x1, x2, h);
    carrier = '0;
    for (int i = 1; i <= h; i++) step(i);
    for (int i = h - 1; i >= 1; i--) step(i);
  endtask

  task automatic flush();
    for (int i = 0; i < 4; i++) step(0);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL R2 watchdog expired: progress=stalled expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);   // R1 reset checks
    rst = 1'b0;

    tag = "R4";                   // all six sectors, R2/R3/R4
    for (int s = 1; s <= 6; s++) period(s, 5, 7, 20);

    tag = "R5";                   // asymmetric and zero-length dwells
    period(2, 3, 11, 24);
    period(3, 0, 9, 16);
    period(5, 8, 0, 16);

    tag = "R6";                   // odd zero time: outer 6, middle 7
    period(4, 4, 4, 21);
    period(1, 0, 0, 9);

    tag = "R7";                   // clamping
    period(6, 15, 10, 20);
    period(3, 30, 3, 20);
    period(2, 12, 8, 20);

    tag = "R8";                   // invalid sectors keep the pair
    period(3, 6, 6, 18);
    period(0, 2, 9, 18);
    period(7, 9, 2, 18);

    tag = "R9";                   // mid-period input change ignored
    @(negedge clk);
    set_in(5, 4, 6, 20);
    carrier = '0;
    for (int i = 1; i <= 20; i++) begin
      step(i);
      if (i == 6) set_in(2, 12, 1, 14);
    end
    for (int i = 19; i >= 1; i--) begin
      step(i);
      if (i == 9) set_in(0, 0, 0, 30);
    end
    period(1, 5, 5, 20);

    tag = "R10";                  // held counts on both slopes
    @(negedge clk);
    set_in(4, 5, 5, 16);
    carrier = '0;
    for (int i = 1; i <= 16; i++) begin
      step(i);
      if (i == 4 || i == 16) begin step(i); step(i); end
    end
    for (int i = 15; i >= 1; i--) begin
      step(i);
      if (i == 12 || i == 2) begin step(i); step(i); step(i); end
    end
    period(6, 3, 3, 12);

    tag = "R1";                   // reset in mid-run
    step(5); step(6);
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    carrier = '0;
    rst = 1'b0;
    tag = "R2";
    period(3, 4, 5, 15);
    flush();

    done = 1;
    summary();
    $finish;
  end

endmodule